// File: doc/BRIEF.md
# I2C Register-Pointer Target

This block is a 7-bit-addressed I2C target that holds a small bank of 8-bit registers. Its inputs are SCL and SDA levels that have already been synchronized and oversampled into the system clock domain. Its only output is an active-high pull-down enable for an external open-drain SDA driver. The block watches the two lines for START, repeated START and STOP. It shifts address and data bytes in and out, and it answers each byte with an ACK or NACK.

A host writes a transaction in this order: the device address with the write bit, a pointer byte that selects a register, and then any number of data bytes. Each data byte is stored at the pointer, and the pointer then advances. To read, the host sets the pointer with a write phase, issues a repeated START, and sends the address with the read bit. The target then sends bytes from the pointer onward and advances the pointer after each byte, until the host answers a byte with NACK. The pointer wraps modulo the register count. A read that starts without a new pointer byte continues from wherever the pointer was left.

Top module: `i2c_regptr_target`

## Requirements
- R1: After reset, sda_pull is 0 and every register reads as 0x00.
- R2: A START (SDA falling while SCL is high) begins address reception from any state. A STOP (SDA rising while SCL is high) returns the target to idle. In idle, clocked bits are not acknowledged and never reach the registers.
- R3: An address byte whose upper seven bits equal DEV_ADDR is acknowledged: sda_pull is 1 through the high phase of the ninth clock. Bit 0 of the byte selects the direction, 0 for write and 1 for read.
- R4: An address byte that does not match gets no ACK. The target does not drive SDA, and it ignores all bytes until the next START, so no register changes.
- R5: The first byte after a matched write address loads the pointer with its value modulo REG_COUNT and is acknowledged.
- R6: Each further write byte is stored at the pointer and acknowledged, and the pointer then advances by one.
- R7: After an address with the read bit, the target sends the register at the current pointer MSB first. It changes SDA only while SCL is low, and the pointer advances by one after every byte it sends. The pointer keeps its value across STOP and START.
- R8: A NACK from the host after a read byte ends transmission. The target releases SDA and drives nothing until the next START or STOP.
- R9: The pointer steps from REG_COUNT-1 to 0, in both write and read bursts.
- R10: During the host's acknowledge clock after a read byte, sda_pull is 0.
- R11: sda_pull changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Synchronized SCL level |
| sda_in | input | 1 | Synchronized SDA level (wired bus value) |
| sda_pull | output | 1 | 1 pulls SDA low through the open-drain driver |

## Verification
A write to the last register and the wrap of the pointer to register 0 happen on the same SCL falling edge. So do the pointer advance after a sent byte and the release of SDA for the host's acknowledge. The bench provokes both by sweeping write bursts that start at every pointer value, so that each burst crosses the top end, and by reading the whole bank plus one further byte in a single burst. It judges the results by reading back against a model array that is updated with modular index arithmetic. A separate read that resumes after a NACK, without a new pointer byte, shows that the pointer advanced exactly once for the byte that was refused.

// File: rtl/i2c_rpt_pkg.sv
package i2c_rpt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACK,
    ST_PTR,
    ST_WDATA,
    ST_RDATA,
    ST_MACK
  } tgt_state_t;

  typedef enum logic [1:0] {
    AK_TO_PTR,
    AK_TO_WDATA,
    AK_TO_RDATA
  } ack_next_t;

  // next pointer value with wrap at the register count
  function automatic int unsigned ptr_step(int unsigned p, int unsigned n);
    return (p + 1 >= n) ? 0 : p + 1;
  endfunction

  // pointer value taken from a received byte
  function automatic int unsigned ptr_load(logic [7:0] b, int unsigned n);
    return 32'(b) % n;
  endfunction

  // address byte comparison (upper seven bits)
  function automatic logic addr_hit(logic [7:0] b, logic [6:0] dev);
    return b[7:1] == dev;
  endfunction

endpackage

// File: rtl/i2c_rpt_line_events.sv
module i2c_rpt_line_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic ev_start,
  output logic ev_stop,
  output logic ev_rise,
  output logic ev_fall
);

  logic scl_q;
  logic sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_in;
      sda_q <= sda_in;
    end
  end

  // SCL edges
  assign ev_rise  = scl_in & ~scl_q;
  assign ev_fall  = ~scl_in & scl_q;
  // SDA edges while SCL stays high
  assign ev_start = scl_in & scl_q & sda_q & ~sda_in;
  assign ev_stop  = scl_in & scl_q & ~sda_q & sda_in;

endmodule

// File: rtl/i2c_rpt_regbank.sv
module i2c_rpt_regbank #(
  parameter int unsigned REG_COUNT = 16,
  parameter int unsigned PW        = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [PW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [PW-1:0] rd_addr,
  output logic [7:0]    rd_data
);

  logic [7:0] regs [REG_COUNT];

  for (genvar i = 0; i < REG_COUNT; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        regs[i] <= 8'h00;
      end else if (wr_en && (32'(wr_addr) == i)) begin
        regs[i] <= wr_data;
      end
    end
  end

  assign rd_data = regs[rd_addr];

endmodule

// File: rtl/i2c_rpt_ctrl.sv
module i2c_rpt_ctrl
  import i2c_rpt_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR  = 7'h2A,
  parameter int unsigned REG_COUNT = 16,
  parameter int unsigned PW        = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sda_in,
  input  logic          ev_start,
  input  logic          ev_stop,
  input  logic          ev_rise,
  input  logic          ev_fall,
  input  logic [7:0]    rd_data,
  output logic          wr_en,
  output logic [7:0]    wr_data,
  output logic [PW-1:0] ptr,
  output logic          rd_en,
  output logic          sda_pull,
  output tgt_state_t    state
);

  logic [3:0] bitcnt;
  logic [7:0] rx_sh;
  logic [7:0] tx_sh;
  logic       host_nack;
  ack_next_t  ack_nxt;
  logic       byte_end;

  assign byte_end = ev_fall && (bitcnt == 4'd8);
  assign wr_en    = (state == ST_WDATA) && byte_end;
  assign wr_data  = rx_sh;
  assign rd_en    = ev_fall &&
                    (((state == ST_ACK) && (ack_nxt == AK_TO_RDATA)) ||
                     ((state == ST_MACK) && !host_nack));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      bitcnt    <= '0;
      rx_sh     <= '0;
      tx_sh     <= '0;
      host_nack <= 1'b1;
      ack_nxt   <= AK_TO_PTR;
      ptr       <= '0;
      sda_pull  <= 1'b0;
    end else if (ev_start) begin
      state    <= ST_ADDR;
      bitcnt   <= '0;
      sda_pull <= 1'b0;
    end else if (ev_stop) begin
      state    <= ST_IDLE;
      bitcnt   <= '0;
      sda_pull <= 1'b0;
    end else begin
      unique case (state)
        ST_ADDR, ST_PTR, ST_WDATA: begin
          if (ev_rise) begin
            rx_sh  <= {rx_sh[6:0], sda_in};
            bitcnt <= bitcnt + 4'd1;
          end else if (byte_end) begin
            if (state == ST_ADDR) begin
              if (addr_hit(rx_sh, DEV_ADDR)) begin
                sda_pull <= 1'b1;
                state    <= ST_ACK;
                ack_nxt  <= rx_sh[0] ? AK_TO_RDATA : AK_TO_PTR;
              end else begin
                state <= ST_IDLE;
              end
            end else if (state == ST_PTR) begin
              ptr      <= PW'(ptr_load(rx_sh, REG_COUNT));
              sda_pull <= 1'b1;
              state    <= ST_ACK;
              ack_nxt  <= AK_TO_WDATA;
            end else begin
              ptr      <= PW'(ptr_step(32'(ptr), REG_COUNT));
              sda_pull <= 1'b1;
              state    <= ST_ACK;
              ack_nxt  <= AK_TO_WDATA;
            end
          end
        end
        ST_ACK: begin
          if (ev_fall) begin
            bitcnt <= '0;
            if (ack_nxt == AK_TO_RDATA) begin
              tx_sh    <= rd_data;
              sda_pull <= ~rd_data[7];
              state    <= ST_RDATA;
            end else begin
              sda_pull <= 1'b0;
              state    <= (ack_nxt == AK_TO_PTR) ? ST_PTR : ST_WDATA;
            end
          end
        end
        ST_RDATA: begin
          if (ev_rise) begin
            bitcnt <= bitcnt + 4'd1;
          end else if (byte_end) begin
            sda_pull <= 1'b0;
            ptr      <= PW'(ptr_step(32'(ptr), REG_COUNT));
            state    <= ST_MACK;
          end else if (ev_fall) begin
            tx_sh    <= {tx_sh[6:0], 1'b0};
            sda_pull <= ~tx_sh[6];
          end
        end
        ST_MACK: begin
          if (ev_rise) begin
            host_nack <= sda_in;
          end else if (ev_fall) begin
            bitcnt <= '0;
            if (host_nack) begin
              sda_pull <= 1'b0;
              state    <= ST_IDLE;
            end else begin
              tx_sh    <= rd_data;
              sda_pull <= ~rd_data[7];
              state    <= ST_RDATA;
            end
          end
        end
        default: begin
          sda_pull <= 1'b0;
        end
      endcase
    end
  end

endmodule

// File: rtl/i2c_regptr_target.sv
module i2c_regptr_target
  import i2c_rpt_pkg::*;
#(
  parameter logic [6:0]  DEV_ADDR  = 7'h2A,
  parameter int unsigned REG_COUNT = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_pull
);

  localparam int unsigned PW = (REG_COUNT > 1) ? $clog2(REG_COUNT) : 1;

  // named internal events, visible to the bound checker
  logic          ev_start;
  logic          ev_stop;
  logic          ev_rise;
  logic          ev_fall;
  logic          wr_en;
  logic          rd_en;
  logic [7:0]    wr_data;
  logic [7:0]    rd_data;
  logic [PW-1:0] ptr;
  tgt_state_t    fsm_state;

  i2c_rpt_line_events u_events (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_in   (scl_in),
    .sda_in   (sda_in),
    .ev_start (ev_start),
    .ev_stop  (ev_stop),
    .ev_rise  (ev_rise),
    .ev_fall  (ev_fall)
  );

  i2c_rpt_ctrl #(
    .DEV_ADDR  (DEV_ADDR),
    .REG_COUNT (REG_COUNT),
    .PW        (PW)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .sda_in   (sda_in),
    .ev_start (ev_start),
    .ev_stop  (ev_stop),
    .ev_rise  (ev_rise),
    .ev_fall  (ev_fall),
    .rd_data  (rd_data),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .ptr      (ptr),
    .rd_en    (rd_en),
    .sda_pull (sda_pull),
    .state    (fsm_state)
  );

  i2c_rpt_regbank #(
    .REG_COUNT (REG_COUNT),
    .PW        (PW)
  ) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (ptr),
    .wr_data (wr_data),
    .rd_addr (ptr),
    .rd_data (rd_data)
  );

endmodule

// File: rtl/i2c_regptr_target_chk.sv
module i2c_regptr_target_chk
  import i2c_rpt_pkg::*;
#(
  parameter int unsigned REG_COUNT = 16,
  parameter int unsigned PW        = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_in,
  input logic          sda_pull,
  input logic          ev_start,
  input logic          ev_stop,
  input logic          wr_en,
  input logic [PW-1:0] ptr,
  input tgt_state_t    st
);

  // R11: the pull-down only moves while SCL is low
  assert_pull_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull) |-> !$past(scl_in));

  // R2: a START leaves SDA released
  assert_start_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> !sda_pull);

  // R2: a STOP returns to idle
  assert_stop_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |=> (st == ST_IDLE));

  // R4: idle never drives the bus
  assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> !sda_pull);

  // R6 / R9: a stored byte advances the pointer with wrap
  assert_ptr_advance_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (32'(ptr) == ptr_step(32'($past(ptr)), REG_COUNT)));

  // R10: the host acknowledge slot is never driven
  assert_mack_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_MACK) |-> !sda_pull);

endmodule

bind i2c_regptr_target i2c_regptr_target_chk #(
  .REG_COUNT (REG_COUNT),
  .PW        (PW)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .scl_in   (scl_in),
  .sda_pull (sda_pull),
  .ev_start (ev_start),
  .ev_stop  (ev_stop),
  .wr_en    (wr_en),
  .ptr      (ptr),
  .st       (fsm_state)
);

// File: tb/i2c_regptr_target_tb.sv
module i2c_regptr_target_tb;

  localparam logic [6:0] DEV = 7'h2A;
  localparam int N = 16;
  localparam int Q = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic sda_m = 1'b1;
  logic sda_line;
  logic sda_pull;

  int checks = 0;
  int errors = 0;
  int r11_viol = 0;
  logic [7:0] model [N];

  always #2.5 clk = ~clk;

  assign sda_line = sda_m & ~sda_pull;

  i2c_regptr_target #(.DEV_ADDR(DEV), .REG_COUNT(N)) u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_in   (scl),
    .sda_in   (sda_line),
    .sda_pull (sda_pull)
  );

  // R11 monitor: pull must not change while SCL is high
  logic pull_prev = 1'b0;
  always @(negedge clk) begin
    if (rst_n && (sda_pull !== pull_prev) && scl) r11_viol++;
    pull_prev = sda_pull;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pattern(int p, int k);
    return 8'((p * 37 + k * 11 + 5) & 255);
  endfunction

  task automatic bus_start();
    sda_m = 1; scl = 1; tick(Q);
    sda_m = 0; tick(Q);
    scl = 0; tick(Q);
  endtask

  task automatic bus_rstart();
    sda_m = 1; tick(Q);
    scl = 1; tick(Q);
    sda_m = 0; tick(Q);
    scl = 0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 0; tick(Q);
    scl = 1; tick(Q);
    sda_m = 1; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q);
      scl = 1; tick(Q);
      scl = 0; tick(Q);
    end
    sda_m = 1; tick(Q);
    scl = 1; tick(Q);
    acked = (sda_line == 1'b0);
    scl = 0; tick(Q);
  endtask

  task automatic recv_byte(output logic [7:0] b, input bit host_ack);
    b = '0;
    for (int i = 0; i < 8; i++) begin
      tick(Q);
      scl = 1; tick(Q);
      b = {b[6:0], sda_line};
      scl = 0;
    end
    tick(Q);
    check(sda_pull == 1'b0, "R10 release before host ack", int'(sda_pull), 0);
    sda_m = ~host_ack; tick(Q);
    scl = 1; tick(Q);
    check(sda_pull == 1'b0, "R10 release during host ack", int'(sda_pull), 0);
    scl = 0; tick(Q);
    sda_m = 1;
  endtask

  task automatic write_burst(int p, int n);
    bit a;
    bus_start();
    send_byte({DEV, 1'b0}, a);
    check(a, "R3 write address ack", int'(a), 1);
    send_byte(8'(p), a);
    check(a, "R5 pointer ack", int'(a), 1);
    for (int k = 0; k < n; k++) begin
      logic [7:0] v;
      v = pattern(p, k);
      send_byte(v, a);
      check(a, "R6 data ack", int'(a), 1);
      model[(p + k) % N] = v;
    end
    bus_stop();
  endtask

  task automatic read_burst(int p, int n, string req);
    bit a;
    logic [7:0] d;
    bus_start();
    send_byte({DEV, 1'b0}, a);
    check(a, "R3 address ack", int'(a), 1);
    send_byte(8'(p), a);
    check(a, "R5 pointer ack", int'(a), 1);
    bus_rstart();
    send_byte({DEV, 1'b1}, a);
    check(a, "R7 read address ack", int'(a), 1);
    for (int k = 0; k < n; k++) begin
      recv_byte(d, k != n - 1);
      check(d == model[(p + k) % N], req, int'(d), int'(model[(p + k) % N]));
    end
    bus_stop();
  endtask

  initial begin
    bit a;
    logic [7:0] d;
    for (int i = 0; i < N; i++) model[i] = 8'h00;
    tick(4);
    check(sda_pull == 1'b0, "R1 pull low in reset", int'(sda_pull), 0);
    rst_n = 1;
    tick(4);
    check(sda_pull == 1'b0, "R1 pull low after reset", int'(sda_pull), 0);

    // R1: whole bank reads zero
    read_burst(0, N, "R1 reset value");

    // R6 R9: write bursts starting at every pointer, crossing the top end
    for (int p = 0; p < N; p++) write_burst(p, 3);

    // R7 R9: full bank plus one byte past the wrap
    read_burst(0, N + 1, "R9 read wrap");

    // R7: short reads from every pointer
    for (int p = 0; p < N; p++) read_burst(p, 2, "R7 read from pointer");

    // R5: pointer byte beyond the bank wraps modulo N; pointer kept across STOP
    bus_start();
    send_byte({DEV, 1'b0}, a);
    send_byte(8'(N + 3), a);
    check(a, "R5 large pointer ack", int'(a), 1);
    send_byte(8'h5A, a);
    model[3] = 8'h5A;
    bus_stop();
    bus_start();
    send_byte({DEV, 1'b1}, a);
    check(a, "R7 read without pointer ack", int'(a), 1);
    recv_byte(d, 1'b0);
    check(d == model[4], "R7 pointer kept across STOP", int'(d), int'(model[4]));
    bus_stop();
    read_burst(3, 1, "R5 modulo pointer store");

    // R4: wrong write address, bytes ignored
    bus_start();
    send_byte({DEV ^ 7'h01, 1'b0}, a);
    check(!a, "R4 no ack for other address", int'(a), 0);
    send_byte(8'h00, a);
    check(!a, "R4 pointer byte ignored", int'(a), 0);
    send_byte(8'hEE, a);
    check(!a, "R4 data byte ignored", int'(a), 0);
    bus_stop();
    read_burst(0, 1, "R4 register unchanged");

    // R4: wrong read address, nothing driven
    bus_start();
    send_byte({DEV ^ 7'h07, 1'b1}, a);
    check(!a, "R4 no ack for other read address", int'(a), 0);
    recv_byte(d, 1'b0);
    check(d == 8'hFF, "R4 bus left released", int'(d), 8'hFF);
    bus_stop();

    // R8: host NACK ends the read; pointer advanced once
    bus_start();
    send_byte({DEV, 1'b0}, a);
    send_byte(8'd6, a);
    bus_rstart();
    send_byte({DEV, 1'b1}, a);
    recv_byte(d, 1'b0);
    check(d == model[6], "R8 byte before nack", int'(d), int'(model[6]));
    for (int i = 0; i < 9; i++) begin
      sda_m = 1; tick(Q);
      scl = 1; tick(Q);
      check(sda_pull == 1'b0, "R8 released after nack", int'(sda_pull), 0);
      scl = 0; tick(Q);
    end
    bus_stop();
    bus_start();
    send_byte({DEV, 1'b1}, a);
    recv_byte(d, 1'b0);
    check(d == model[7], "R8 resume after nack", int'(d), int'(model[7]));
    bus_stop();

    // R2: after STOP, clocked bits are not taken
    bus_start();
    send_byte({DEV, 1'b0}, a);
    send_byte(8'd9, a);
    bus_stop();
    scl = 0; tick(Q);
    send_byte(8'h77, a);
    check(!a, "R2 idle after STOP", int'(a), 0);
    bus_stop();
    bus_start();
    send_byte({DEV, 1'b1}, a);
    recv_byte(d, 1'b0);
    check(d == model[9], "R2 register unchanged after STOP", int'(d), int'(model[9]));
    bus_stop();

    // R11: pull changed only with SCL low
    check(r11_viol == 0, "R11 pull changes with SCL high", r11_viol, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule